// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the execute stage of a pipelined processor that uses delayed branches. Each cycle it looks at the synchronous exception raised by the current instruction and at the non-maskable and ordinary interrupt lines. It then chooses one outcome: enter a handler, hold the interrupt for later, force a manual reset, or carry out a return-from-exception instruction. On handler entry it works out the return address and the saved status from the kind of event and the instruction's place in the branch/slot pair. It captures these, together with an event code, in its own saved-PC, saved-status and event-code registers.

The block drives the next-PC selector, a status-register write port and a reset request. The fetch unit, decoder, vector lookup and interrupt priority arbitration are outside it. An ordinary interrupt or NMI that cannot be taken is latched until it can be. The status register holds a block bit and a privilege bit, at positions set by parameters. Both are used by the acceptance rules and set on entry.

Top module: `exc_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `spc`, `ssr` and `evt` read zero, both pending latches are clear, and with idle inputs `pc_src` is 0 (sequential), with `sr_we` and `rst_req` low.
- R2: When `rte_exec` is taken, in the same cycle `pc_src` is 2 (restore), `pc_tgt` equals `spc`, `sr_we` is 1 and `sr_wdata` equals `ssr`. A return is taken only when no exception is raised and no interrupt is accepted that cycle.
- R3: In the cycle after a taken return, an exception with `exc_fetch`=1 is judged against the block bit of `sr_in` as sampled in the return cycle. Any other exception is judged against the current `sr_in`.
- R4: An exception raised while its governing block bit (bit `BL_BIT`, default 28) is 1, and with `exc_ubrk`=0, gives `rst_req`=1 and `pc_src`=3 in the same cycle. After the next edge `spc` holds that cycle's `cur_pc`, `evt` holds 0x00000020 and `ssr` is unchanged.
- R5: An exception with `exc_ubrk`=1 raised while its governing block bit is 1 is dropped. That cycle has `pc_src`=0, `sr_we`=0, `rst_req`=0, and `spc`, `ssr` and `evt` do not change.
- R6: An ordinary interrupt seen while the block bit is 1 (not low power) is not taken. It stays pending with no need to re-request, and is taken in the first cycle that the block bit reads 0 and nothing of higher rank is present.
- R7: With the block bit at 1, a present or pending NMI is taken when `nmi_unblock`=1. Otherwise it stays pending.
- R8: While `low_power`=1, present or pending interrupts are taken whatever the block bit holds.
- R9: For an accepted exception with `exc_complete`=0 (re-execute), `spc` becomes `cur_pc`, or `dslot_br_pc` when `in_dslot`=1.
- R10: For an accepted exception with `exc_complete`=1, and for any accepted interrupt, `spc` becomes `nxt_pc`, or `br_tgt` when `is_dbranch`=1.
- R11: On any accepted entry, the same cycle shows `pc_src`=1 (handler), `sr_we`=1 and `sr_wdata` = `sr_in` with bits `BL_BIT` and `MD_BIT` (default 30) set. At the next edge `spc`, `ssr` (= that cycle's `sr_in`) and `evt` all update together. In cycles with no entry or reset they hold.
- R12: Rank order is exception, then NMI, then ordinary interrupt, then return. A lower-ranked interrupt that is present stays pending.
- R13: On entry `evt` receives `exc_code`, `nmi_code` or `irq_code` according to which source was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Current instruction raises an exception |
| exc_complete | input | 1 | 1 = completion type, 0 = re-execute type |
| exc_ubrk | input | 1 | Exception is a user break |
| exc_fetch | input | 1 | Exception comes from instruction access |
| exc_code | input | CW | Event code for this exception |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_code | input | CW | Event code for NMI |
| nmi_unblock | input | 1 | Software setting: accept NMI while blocked |
| irq_req | input | 1 | Ordinary interrupt request |
| irq_code | input | CW | Event code for ordinary interrupt |
| cur_pc | input | AW | PC of the current instruction |
| nxt_pc | input | AW | PC of the following instruction |
| br_tgt | input | AW | Destination of the current delayed branch |
| is_dbranch | input | 1 | Current instruction is a delayed branch |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| dslot_br_pc | input | AW | PC of the branch that owns the slot |
| low_power | input | 1 | Sleep or standby state |
| sr_in | input | SRW | Current status register |
| rte_exec | input | 1 | Return-from-exception executes |
| pc_src | output | 2 | 0 sequential, 1 handler, 2 restore, 3 reset |
| pc_tgt | output | AW | Return address for restore |
| sr_we | output | 1 | Status register write enable |
| sr_wdata | output | SRW | Status register write value |
| spc | output | AW | Saved PC register |
| ssr | output | SRW | Saved status register |
| evt | output | CW | Event code register |
| rst_req | output | 1 | Manual reset request |

## Verification
`pc_src`, `pc_tgt`, `sr_we`, `sr_wdata` and `rst_req` are combinational, so they are due in the cycle that raises the event. The bench drives inputs on the falling edge and checks these outputs 1 ns later. `spc`, `ssr` and `evt` change at the following rising edge, so they are compared at the next falling edge against a bench model that advances one step per cycle. Pending interrupts and the status latched at a return carry over between cycles in the model too. This lets deferred acceptance and the slot after a return be checked in the exact cycle that they act.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [1:0] {
        PC_SEQ     = 2'd0,
        PC_HANDLER = 2'd1,
        PC_RESTORE = 2'd2,
        PC_RESET   = 2'd3
    } pc_src_e;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_ENTER,
        ACT_RESET,
        ACT_RETURN
    } act_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_EXC,
        SRC_NMI,
        SRC_IRQ
    } src_e;

    typedef struct packed {
        act_e act;
        src_e src;
        logic take_nmi;
        logic take_irq;
    } decision_t;

    localparam int NUM_INT = 2;
    localparam int IDX_NMI = 0;
    localparam int IDX_IRQ = 1;

    function automatic pc_src_e act_to_src(act_e a);
        case (a)
            ACT_ENTER:  return PC_HANDLER;
            ACT_RESET:  return PC_RESET;
            ACT_RETURN: return PC_RESTORE;
            default:    return PC_SEQ;
        endcase
    endfunction

endpackage

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] take,
    output logic [N-1:0] any
);
    logic [N-1:0] held_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign any[i] = req[i] | held_q[i];
        always_ff @(posedge clk) begin
            if (rst) held_q[i] <= 1'b0;
            else     held_q[i] <= any[i] & ~take[i];
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic      exc_req,
    input  logic      exc_ubrk,
    input  logic      blk_exc,
    input  logic      blk_int,
    input  logic      low_power,
    input  logic      nmi_any,
    input  logic      nmi_unblock,
    input  logic      irq_any,
    input  logic      rte_exec,
    output decision_t dec
);
    logic nmi_ok, irq_ok;

    assign nmi_ok = nmi_any & (~blk_int | nmi_unblock | low_power);
    assign irq_ok = irq_any & (~blk_int | low_power);

    always_comb begin
        dec = '{act: ACT_IDLE, src: SRC_NONE, take_nmi: 1'b0, take_irq: 1'b0};
        if (exc_req) begin
            if (!blk_exc) begin
                dec.act = ACT_ENTER;
                dec.src = SRC_EXC;
            end else if (!exc_ubrk) begin
                dec.act = ACT_RESET;
            end
        end else if (nmi_ok) begin
            dec.act      = ACT_ENTER;
            dec.src      = SRC_NMI;
            dec.take_nmi = 1'b1;
        end else if (irq_ok) begin
            dec.act      = ACT_ENTER;
            dec.src      = SRC_IRQ;
            dec.take_irq = 1'b1;
        end else if (rte_exec) begin
            dec.act = ACT_RETURN;
        end
    end
endmodule

// File: rtl/exc_spc_sel.sv
module exc_spc_sel #(
    parameter int AW = 32
) (
    input  logic          reexec,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] nxt_pc,
    input  logic [AW-1:0] br_tgt,
    input  logic          is_dbranch,
    input  logic          in_dslot,
    input  logic [AW-1:0] dslot_br_pc,
    output logic [AW-1:0] spc_new
);
    logic [AW-1:0] rerun_pc, resume_pc;

    assign rerun_pc  = in_dslot   ? dslot_br_pc : cur_pc;
    assign resume_pc = is_dbranch ? br_tgt      : nxt_pc;
    assign spc_new   = reexec     ? rerun_pc    : resume_pc;
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          SRW      = 32,
    parameter int          CW       = 32,
    parameter int          BL_BIT   = 28,
    parameter int          MD_BIT   = 30,
    parameter logic [31:0] RST_CODE = 32'h0000_0020
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           exc_req,
    input  logic           exc_complete,
    input  logic           exc_ubrk,
    input  logic           exc_fetch,
    input  logic [CW-1:0]  exc_code,
    input  logic           nmi_req,
    input  logic [CW-1:0]  nmi_code,
    input  logic           nmi_unblock,
    input  logic           irq_req,
    input  logic [CW-1:0]  irq_code,
    input  logic [AW-1:0]  cur_pc,
    input  logic [AW-1:0]  nxt_pc,
    input  logic [AW-1:0]  br_tgt,
    input  logic           is_dbranch,
    input  logic           in_dslot,
    input  logic [AW-1:0]  dslot_br_pc,
    input  logic           low_power,
    input  logic [SRW-1:0] sr_in,
    input  logic           rte_exec,
    output logic [1:0]     pc_src,
    output logic [AW-1:0]  pc_tgt,
    output logic           sr_we,
    output logic [SRW-1:0] sr_wdata,
    output logic [AW-1:0]  spc,
    output logic [SRW-1:0] ssr,
    output logic [CW-1:0]  evt,
    output logic           rst_req
);
    localparam logic [SRW-1:0] ENTRY_SET = (SRW'(1) << BL_BIT) | (SRW'(1) << MD_BIT);

    logic [AW-1:0]      spc_q, spc_new;
    logic [SRW-1:0]     ssr_q, pre_sr_q;
    logic [CW-1:0]      evt_q, code_sel;
    logic               slot_q, blk_exc;
    logic [NUM_INT-1:0] int_req, int_take, int_any;
    decision_t          dec;

    assign blk_exc = (slot_q && exc_fetch) ? pre_sr_q[BL_BIT] : sr_in[BL_BIT];

    assign int_req[IDX_NMI]  = nmi_req;
    assign int_req[IDX_IRQ]  = irq_req;
    assign int_take[IDX_NMI] = dec.take_nmi;
    assign int_take[IDX_IRQ] = dec.take_irq;

    exc_pend_latch #(.N(NUM_INT)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .req  (int_req),
        .take (int_take),
        .any  (int_any)
    );

    exc_arbiter u_arb (
        .exc_req     (exc_req),
        .exc_ubrk    (exc_ubrk),
        .blk_exc     (blk_exc),
        .blk_int     (sr_in[BL_BIT]),
        .low_power   (low_power),
        .nmi_any     (int_any[IDX_NMI]),
        .nmi_unblock (nmi_unblock),
        .irq_any     (int_any[IDX_IRQ]),
        .rte_exec    (rte_exec),
        .dec         (dec)
    );

    exc_spc_sel #(.AW(AW)) u_spc (
        .reexec      (dec.src == SRC_EXC && !exc_complete),
        .cur_pc      (cur_pc),
        .nxt_pc      (nxt_pc),
        .br_tgt      (br_tgt),
        .is_dbranch  (is_dbranch),
        .in_dslot    (in_dslot),
        .dslot_br_pc (dslot_br_pc),
        .spc_new     (spc_new)
    );

    always_comb begin
        case (dec.src)
            SRC_NMI: code_sel = nmi_code;
            SRC_IRQ: code_sel = irq_code;
            default: code_sel = exc_code;
        endcase
    end

    assign pc_src   = act_to_src(dec.act);
    assign pc_tgt   = spc_q;
    assign sr_we    = (dec.act == ACT_ENTER) || (dec.act == ACT_RETURN);
    assign sr_wdata = (dec.act == ACT_RETURN) ? ssr_q : (sr_in | ENTRY_SET);
    assign rst_req  = (dec.act == ACT_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            spc_q    <= '0;
            ssr_q    <= '0;
            evt_q    <= '0;
            pre_sr_q <= '0;
            slot_q   <= 1'b0;
        end else begin
            slot_q <= (dec.act == ACT_RETURN);
            case (dec.act)
                ACT_ENTER: begin
                    spc_q <= spc_new;
                    ssr_q <= sr_in;
                    evt_q <= code_sel;
                end
                ACT_RESET: begin
                    spc_q <= cur_pc;
                    evt_q <= CW'(RST_CODE);
                end
                ACT_RETURN: pre_sr_q <= sr_in;
                default: ;
            endcase
        end
    end

    assign spc = spc_q;
    assign ssr = ssr_q;
    assign evt = evt_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_seq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          SRW      = 32,
    parameter int          CW       = 32,
    parameter int          BL_BIT   = 28,
    parameter logic [31:0] RST_CODE = 32'h0000_0020
) (
    input logic           clk,
    input logic           rst,
    input logic           exc_req,
    input logic [CW-1:0]  exc_code,
    input logic [AW-1:0]  cur_pc,
    input logic [SRW-1:0] sr_in,
    input logic           low_power,
    input logic           nmi_unblock,
    input logic [1:0]     pc_src,
    input logic [AW-1:0]  pc_tgt,
    input logic           sr_we,
    input logic [SRW-1:0] sr_wdata,
    input logic [AW-1:0]  spc,
    input logic [SRW-1:0] ssr,
    input logic [CW-1:0]  evt,
    input logic           rst_req
);
    AST_RESET_SAVES: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (spc == $past(cur_pc) && evt == CW'(RST_CODE))); // R4
    AST_RESET_SSR_HELD: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> $stable(ssr)); // R4
    AST_ENTRY_SSR: assert property (@(posedge clk) disable iff (rst)
        (pc_src == PC_HANDLER) |=> (ssr == $past(sr_in))); // R11
    AST_ENTRY_CODE: assert property (@(posedge clk) disable iff (rst)
        (pc_src == PC_HANDLER && exc_req) |=> (evt == $past(exc_code))); // R13
    AST_RESTORE_PATH: assert property (@(posedge clk) disable iff (rst)
        (pc_src == PC_RESTORE) |-> (pc_tgt == spc && sr_we && sr_wdata == ssr)); // R2
    AST_BLOCKED_INT: assert property (@(posedge clk) disable iff (rst)
        (pc_src == PC_HANDLER && sr_in[BL_BIT] && !low_power && !exc_req) |-> nmi_unblock); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pc_src == PC_SEQ) |=> ($stable(spc) && $stable(ssr) && $stable(evt))); // R11
endmodule

bind exc_seq_ctrl exc_seq_chk #(
    .AW(AW), .SRW(SRW), .CW(CW), .BL_BIT(BL_BIT), .RST_CODE(RST_CODE)
) u_chk (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
    .cur_pc(cur_pc), .sr_in(sr_in), .low_power(low_power),
    .nmi_unblock(nmi_unblock), .pc_src(pc_src), .pc_tgt(pc_tgt),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .spc(spc), .ssr(ssr),
    .evt(evt), .rst_req(rst_req)
);

// File: tb/exc_seq_ctrl_test.sv
module exc_seq_ctrl_test;
    localparam logic [31:0] BLM = 32'h1000_0000;
    localparam logic [31:0] MDM = 32'h4000_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, exc_req, exc_complete, exc_ubrk, exc_fetch, nmi_req, nmi_unblock, irq_req;
    logic is_dbranch, in_dslot, low_power, rte_exec, sr_we, rst_req;
    logic [31:0] exc_code, nmi_code, irq_code, cur_pc, nxt_pc, br_tgt, dslot_br_pc, sr_in;
    logic [31:0] pc_tgt, sr_wdata, spc, ssr, evt;
    logic [1:0]  pc_src;

    exc_seq_ctrl uut (.*);

    int n_tests = 0, n_fail = 0;
    logic [31:0] m_spc, m_ssr, m_evt, m_pre;
    logic m_ip, m_np, m_slot;
    string last_tag;

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [31:0] resume_pc();
        return is_dbranch ? br_tgt : nxt_pc;
    endfunction

    task automatic idle_inputs();
        exc_req = 0; exc_complete = 0; exc_ubrk = 0; exc_fetch = 0; nmi_req = 0;
        nmi_unblock = 0; irq_req = 0; is_dbranch = 0; in_dslot = 0; low_power = 0;
        rte_exec = 0; exc_code = 0; nmi_code = 0; irq_code = 0; cur_pc = 0;
        nxt_pc = 0; br_tgt = 0; dslot_br_pc = 0; sr_in = 0;
    endtask

    // Model one cycle: compare combinational outputs, then advance model state.
    task automatic model_step();
        logic bl_i, bl_x, nmi_any, irq_any, tn, ti, e_we, e_rst;
        logic [1:0] e_src;
        logic [31:0] e_wd, e_tgt;
        string tag;
        bl_i = sr_in[28];
        bl_x = (m_slot && exc_fetch) ? m_pre[28] : bl_i;
        nmi_any = nmi_req | m_np;
        irq_any = irq_req | m_ip;
        tn = 0; ti = 0; e_we = 0; e_rst = 0; e_src = 0; e_wd = 0; e_tgt = 0; tag = "R12";
        if (exc_req) begin
            if (bl_x && !exc_ubrk) begin
                e_src = 3; e_rst = 1; m_spc = cur_pc; m_evt = 32'h20; tag = "R4";
            end else if (bl_x) begin
                tag = "R5";
            end else begin
                e_src = 1; e_we = 1; e_wd = sr_in | BLM | MDM; m_ssr = sr_in; m_evt = exc_code;
                m_spc = exc_complete ? resume_pc() : (in_dslot ? dslot_br_pc : cur_pc);
                tag = exc_complete ? "R10" : "R9";
            end
            if (m_slot && exc_fetch) tag = "R3";
        end else if (nmi_any && (!bl_i || nmi_unblock || low_power)) begin
            e_src = 1; e_we = 1; e_wd = sr_in | BLM | MDM; tn = 1;
            m_spc = resume_pc(); m_ssr = sr_in; m_evt = nmi_code; tag = "R7";
        end else if (irq_any && (!bl_i || low_power)) begin
            e_src = 1; e_we = 1; e_wd = sr_in | BLM | MDM; ti = 1;
            m_spc = resume_pc(); m_ssr = sr_in; m_evt = irq_code;
            tag = (bl_i && low_power) ? "R8" : "R6";
        end else if (rte_exec) begin
            e_src = 2; e_we = 1; e_wd = m_ssr; e_tgt = m_spc; tag = "R2";
        end else if (nmi_any || irq_any) begin
            tag = "R6";
        end
        chk(tag, "pc_src", 32'(pc_src), 32'(e_src));
        chk(tag, "sr_we", 32'(sr_we), 32'(e_we));
        chk(tag, "rst_req", 32'(rst_req), 32'(e_rst));
        if (e_we) chk((e_src == 2) ? "R2" : "R11", "sr_wdata", sr_wdata, e_wd);
        if (e_src == 2) chk("R2", "pc_tgt", pc_tgt, e_tgt);
        m_np = nmi_any & ~tn;
        m_ip = irq_any & ~ti;
        m_slot = (e_src == 2);
        if (e_src == 2) m_pre = sr_in;
        last_tag = tag;
    endtask

    // Inputs already set at a falling edge; runs to the next falling edge.
    task automatic run_cycle();
        #1;
        model_step();
        @(negedge clk);
        chk(last_tag, "spc", spc, m_spc);
        chk((last_tag == "R4") ? "R4" : "R11", "ssr", ssr, m_ssr);
        chk((last_tag == "R4") ? "R4" : "R13", "evt", evt, m_evt);
        idle_inputs();
        sr_in = 32'h0000_00F0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst = 1;
        m_spc = 0; m_ssr = 0; m_evt = 0; m_pre = 0; m_ip = 0; m_np = 0; m_slot = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "spc", spc, 0); chk("R1", "ssr", ssr, 0); chk("R1", "evt", evt, 0);
        chk("R1", "pc_src", 32'(pc_src), 0); chk("R1", "rst_req", 32'(rst_req), 0);
        rst = 0;
        run_cycle();

        // R6: interrupt while blocked, then released
        sr_in = BLM; irq_req = 1; irq_code = 32'h500; nxt_pc = 32'h100; run_cycle();
        sr_in = BLM; run_cycle();
        sr_in = 0; nxt_pc = 32'h204; #1;
        chk("R6", "pending irq taken", 32'(pc_src), 1);
        #0; run_cycle();
        // R7: NMI blocked then unblocked by setting
        sr_in = BLM; nmi_req = 1; nmi_code = 32'h1C0; run_cycle();
        sr_in = BLM; nmi_unblock = 1; is_dbranch = 1; br_tgt = 32'h880; run_cycle();
        // R8: low power accepts blocked interrupt
        sr_in = BLM; irq_req = 1; irq_code = 32'h620; low_power = 1; nxt_pc = 32'h40; run_cycle();
        // R12: exception beats both interrupts, which stay pending
        exc_req = 1; exc_code = 32'h0E0; cur_pc = 32'h300; nmi_req = 1; irq_req = 1; run_cycle();
        run_cycle(); run_cycle();
        // R9 delay slot re-execute
        exc_req = 1; in_dslot = 1; dslot_br_pc = 32'h3FC; cur_pc = 32'h400; exc_code = 32'h40; run_cycle();
        // R10 completion on delayed branch
        exc_req = 1; exc_complete = 1; is_dbranch = 1; br_tgt = 32'h7700; exc_code = 32'h160; run_cycle();
        // R4 blocked exception -> reset; R5 blocked user break dropped
        sr_in = BLM; exc_req = 1; cur_pc = 32'h5550; run_cycle();
        sr_in = BLM; exc_req = 1; exc_ubrk = 1; cur_pc = 32'h6660; run_cycle();
        // R2/R3: return with SR block clear, slot fetch exception judged on old SR
        sr_in = 32'h0000_0003; rte_exec = 1; run_cycle();
        sr_in = BLM; exc_req = 1; exc_fetch = 1; exc_code = 32'h0A0; cur_pc = 32'h910; run_cycle();
        sr_in = BLM; rte_exec = 1; run_cycle();
        sr_in = BLM; exc_req = 1; exc_fetch = 0; cur_pc = 32'h920; run_cycle();

        for (int i = 0; i < 3000; i++) begin
            exc_req      = ($urandom % 5) == 0;
            exc_complete = $urandom % 2;
            exc_ubrk     = ($urandom % 4) == 0;
            exc_fetch    = $urandom % 2;
            nmi_req      = ($urandom % 10) == 0;
            nmi_unblock  = $urandom % 2;
            irq_req      = ($urandom % 6) == 0;
            rte_exec     = ($urandom % 4) == 0;
            low_power    = ($urandom % 8) == 0;
            is_dbranch   = $urandom % 2;
            in_dslot     = $urandom % 2;
            exc_code = $urandom; nmi_code = $urandom; irq_code = $urandom;
            cur_pc = $urandom; nxt_pc = $urandom; br_tgt = $urandom; dslot_br_pc = $urandom;
            sr_in = $urandom;
            run_cycle();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule